// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a PLL to a new frequency in one fixed order. A one-cycle `start` pulse captures the requested rate in Hz and a configuration: input divider, feedback divider, output divider, band and a bypass flag. From these the block writes the PLL control word. It then waits a fixed lock interval and samples the PLL lock and error status. It finishes with a one-cycle `done` pulse and a result code.

The block also drives a select for the divider of the interface clock. When the target rate is above a threshold, the interface clock is switched to divide-by-2 before the PLL is touched. It is switched back to divide-by-1 only after a retune below the threshold has been confirmed good. The PLL is therefore never running fast while the interface divider is at 1. The rate table, bus access and the analog PLL are outside the block.

Top module: `pll_retune_seq`

## Requirements
- R1: In reset and right after it, `ctrl_word` is 32'h00000001 (power-down set), `ifdiv_sel` is 0, `busy` is 0, `done` is 0 and `result` is 2'b00.
- R2: With `bypass` clear, the written word has power-down (bit 0) and bypass (bit 1) at 0, the output divider in bits 3:2, the input divider in bits 8:4, the feedback divider in bits 15:9, bits 19:16 at 0, the band at bit 20 and up, and every bit above the band at 0.
- R3: With `bypass` set, the written word is the previous `ctrl_word` with bit 1 set and all other bits kept.
- R4: When `rate` is above RATE_THR (default 500,000,000), `ifdiv_sel` becomes 1 in the cycle after start. The control word is written one cycle later. At a rate equal to or below the threshold, the select is not changed at that point.
- R5: The control word changes one cycle after the start is accepted. `done` rises WAIT_CYC cycles after that write, with WAIT_CYC = (CLK_HZ/1,000,000)·LOCK_US. The status inputs are sampled at the edge that raises `done`.
- R6: If `pll_lock` is low when sampled, `result` is 2'b01 (timeout), whatever the value of `pll_err`.
- R7: If `pll_lock` is high and `pll_err` is high when sampled, `result` is 2'b10 (error). If `pll_lock` is high and `pll_err` is low, `result` is 2'b00 (ok).
- R8: `ifdiv_sel` is cleared to 0 with `done` only when the result is ok and the rate is at or below the threshold. After a timeout or an error it keeps its value.
- R9: A `start` while `busy` is high is ignored: it does not change the word, the select, the timing of `done` or the result.
- R10: `done` lasts one cycle, and `busy` is low in that cycle. `busy` is high from the cycle after an accepted start until then. `result` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a retune (one-cycle pulse) |
| rate | input | 32 | Requested rate in Hz |
| in_div | input | 5 | Input divider field |
| fb_div | input | 7 | Feedback divider field |
| out_div | input | 2 | Output divider field |
| band | input | BAND_W | Band field |
| bypass | input | 1 | Bypass the PLL instead of reprogramming |
| pll_lock | input | 1 | PLL lock status |
| pll_err | input | 1 | PLL error status |
| ctrl_word | output | 32 | PLL control word |
| ifdiv_sel | output | 1 | Interface divider select: 1 = divide by 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 timeout, 10 error |

## Verification
A wrong count in the wait counter shows directly as `done` arriving early or late compared with the control-word write. The bench checks every cycle of the wait for an early pulse. A wrong latched threshold flag or bypass flag shows within two cycles of start as a wrong `ifdiv_sel` or a wrong `ctrl_word`. A wrong outcome decode shows in `result` and in the final select in the same cycle as `done`. One scenario pulses a second start with different inputs during a wait, to catch a sequencer that re-enters or re-samples its configuration.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int          CLK_HZ   = 100_000_000,
  parameter int          LOCK_US  = 100,
  parameter int          BAND_W   = 4,
  parameter logic [31:0] RATE_THR = 32'd500_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       rate,
  input  logic [4:0]        in_div,
  input  logic [6:0]        fb_div,
  input  logic [1:0]        out_div,
  input  logic [BAND_W-1:0] band,
  input  logic              bypass,
  input  logic              pll_lock,
  input  logic              pll_err,
  output logic [31:0]       ctrl_word,
  output logic              ifdiv_sel,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * LOCK_US;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);
  localparam int TOP_W    = 32 - 20 - BAND_W;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_PREP = 2'd1, ST_WAIT = 2'd2;
  localparam logic [1:0] RES_OK = 2'b00, RES_TMO = 2'b01, RES_ERR = 2'b10;

  logic [1:0]        st;
  logic [CNT_W-1:0]  cnt;
  logic [4:0]        id_q;
  logic [6:0]        fb_q;
  logic [1:0]        od_q;
  logic [BAND_W-1:0] band_q;
  logic              byp_q, big_q;
  logic [31:0]       new_word;

  assign new_word = {{TOP_W{1'b0}}, band_q, 4'b0000, fb_q, id_q, od_q, 2'b00};
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      id_q <= '0;
      fb_q <= '0;
      od_q <= '0;
      band_q <= '0;
      byp_q <= 1'b0;
      big_q <= 1'b0;
      ctrl_word <= 32'h0000_0001;
      ifdiv_sel <= 1'b0;
      done <= 1'b0;
      result <= RES_OK;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          id_q <= in_div;
          fb_q <= fb_div;
          od_q <= out_div;
          band_q <= band;
          byp_q <= bypass;
          big_q <= (rate > RATE_THR);
          if (rate > RATE_THR) ifdiv_sel <= 1'b1;
          st <= ST_PREP;
        end
        ST_PREP: begin
          ctrl_word <= byp_q ? (ctrl_word | 32'h0000_0002) : new_word;
          cnt <= '0;
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(WAIT_CYC - 1)) begin
            done <= 1'b1;
            st <= ST_IDLE;
            if (!pll_lock) result <= RES_TMO;
            else if (pll_err) result <= RES_ERR;
            else begin
              result <= RES_OK;
              if (!big_q) ifdiv_sel <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R4
  ifdiv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_word != $past(ctrl_word)) && big_q) |-> (ifdiv_sel && $past(ifdiv_sel)));
  // R8
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != RES_OK) |-> $stable(ifdiv_sel));
  // R9
  busy_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |=> $stable(ctrl_word));
endmodule

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;
  localparam int LOCK_US  = 5;
  localparam int WAIT_CYC = 100 * LOCK_US;
  localparam logic [31:0] THR = 32'd500_000_000;

  logic clk = 0, rst_n = 0, start = 0, bypass = 0, pll_lock = 0, pll_err = 0;
  logic [31:0] rate = '0;
  logic [4:0] in_div = '0;
  logic [6:0] fb_div = '0;
  logic [1:0] out_div = '0;
  logic [3:0] band = '0;
  logic [31:0] ctrl_word;
  logic ifdiv_sel, busy, done;
  logic [1:0] result;

  int checks = 0, fails = 0;
  logic [31:0] cur_word;
  logic cur_if;

  always #5 clk = ~clk;

  pll_retune_seq #(.CLK_HZ(100_000_000), .LOCK_US(LOCK_US), .BAND_W(4), .RATE_THR(THR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rate(rate), .in_div(in_div),
    .fb_div(fb_div), .out_div(out_div), .band(band), .bypass(bypass),
    .pll_lock(pll_lock), .pll_err(pll_err), .ctrl_word(ctrl_word),
    .ifdiv_sel(ifdiv_sel), .busy(busy), .done(done), .result(result));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [31:0] r, input logic [4:0] id, input logic [6:0] fb,
                         input logic [1:0] od, input logic [3:0] bd, input logic byp,
                         input logic lk, input logic er, input bit inject);
    logic [31:0] exp_word;
    logic exp_mid, exp_end;
    logic [1:0] exp_res, prev_res;
    bit early;
    exp_word = byp ? (cur_word | 32'h2) : {8'h0, bd, 4'h0, fb, id, od, 2'b00};
    exp_mid  = (r > THR) ? 1'b1 : cur_if;
    exp_res  = !lk ? 2'b01 : (er ? 2'b10 : 2'b00);
    exp_end  = (exp_res == 2'b00 && r <= THR) ? 1'b0 : exp_mid;
    prev_res = result;
    @(negedge clk);
    rate = r; in_div = id; fb_div = fb; out_div = od; band = bd; bypass = byp;
    pll_lock = lk; pll_err = er; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R10 busy after start", 32'(busy), 1);
    chk(ifdiv_sel === exp_mid, "R4 select before write", 32'(ifdiv_sel), 32'(exp_mid));
    chk(ctrl_word === cur_word, "R4 word not yet written", ctrl_word, cur_word);
    @(negedge clk);
    chk(ctrl_word === exp_word, byp ? "R3 bypass word" : "R2 word fields", ctrl_word, exp_word);
    early = 0;
    for (int i = 1; i < WAIT_CYC; i++) begin
      if (inject && i == 50) begin
        start = 1; rate = 32'd900_000_000; bypass = ~byp; fb_div = 7'd3;
        pll_lock = 0;
      end
      if (inject && i == 51) begin
        start = 0; pll_lock = lk;
      end
      @(negedge clk);
      if (done !== 1'b0) early = 1;
      if (result !== prev_res) early = 1;
    end
    chk(!early, "R5 R10 no early done or result change", 32'(early), 0);
    if (inject) begin
      chk(ctrl_word === exp_word, "R9 word after ignored start", ctrl_word, exp_word);
      chk(ifdiv_sel === exp_mid, "R9 select after ignored start", 32'(ifdiv_sel), 32'(exp_mid));
    end
    @(negedge clk);
    chk(done === 1'b1, "R5 done at end of wait", 32'(done), 1);
    chk(busy === 1'b0, "R10 busy low with done", 32'(busy), 0);
    chk(result === exp_res, exp_res == 2'b01 ? "R6 timeout" : (exp_res == 2'b10 ? "R7 error" : "R7 ok"),
        32'(result), 32'(exp_res));
    chk(ifdiv_sel === exp_end, "R8 select after done", 32'(ifdiv_sel), 32'(exp_end));
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", 32'(done), 0);
    chk(result === exp_res, "R10 result held", 32'(result), 32'(exp_res));
    cur_word = exp_word;
    cur_if = exp_end;
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ctrl_word === 32'h1, "R1 reset word", ctrl_word, 32'h1);
    chk(ifdiv_sel === 1'b0, "R1 reset select", 32'(ifdiv_sel), 0);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {30'b0, busy, done}, 0);
    chk(result === 2'b00, "R1 reset result", 32'(result), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_word === 32'h1 && busy === 1'b0, "R1 after release", ctrl_word, 32'h1);
    cur_word = 32'h1;
    cur_if = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_seq(32'd600_000_000, 5'd0, 7'd17, 2'd1, 4'd0, 1'b0, 1'b1, 1'b0, 0);
    run_seq(32'd200_000_000, 5'd1, 7'd47, 2'd3, 4'd2, 1'b0, 1'b1, 1'b0, 0);
    run_seq(32'd1_000_000_000, 5'd1, 7'd29, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 0);
    run_seq(32'd300_000_000, 5'd1, 7'd35, 2'd2, 4'd15, 1'b0, 1'b1, 1'b1, 0);
    run_seq(32'd27_000_000, 5'd0, 7'd0, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 0);
    run_seq(32'd500_000_000, 5'd0, 7'd14, 2'd1, 4'd0, 1'b0, 1'b1, 1'b0, 1);
    run_seq(32'd500_000_001, 5'd31, 7'd127, 2'd3, 4'd9, 1'b0, 1'b1, 1'b0, 0);
    run_seq(32'd150_000_000, 5'd0, 7'd21, 2'd3, 4'd0, 1'b0, 1'b0, 1'b0, 0);
    run_seq(32'd700_000_000, 5'd0, 7'd20, 2'd1, 4'd0, 1'b1, 1'b1, 1'b0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule